// File: doc/BRIEF.md
# Little-Endian Byte-Serial Load/Store Unit

This unit carries out the memory operations of a 64-bit register machine on a data memory that has a byte-wide port and one address per byte. Each request gives an operation code and two register operand values. It may also carry a 32-bit immediate. The unit then runs the whole transfer on its own. A 64-bit word goes over the port as eight single-byte accesses. The least significant byte goes to the lowest address, and the address steps up by one on each access.

The four operations work as follows:
- A load reads the word at the address in operand B and returns it for writeback.
- A store writes operand A to the address in operand B.
- A copy reads the word at the address in operand B and writes it to the address in operand A, without using any register.
- An immediate move returns the zero-extended constant for writeback with no memory access.

The register file picks up the writeback on a one-cycle done pulse, which is qualified by a valid strobe.

Top module: `le_lsu`

## Requirements
- R1: Byte k (k = 0..7) of a word maps to address base+k. It holds bits [8k+7:8k], so the least significant byte sits at the lowest address.
- R2: Load (op 0) reads base = operand B for 8 cycles. It then gives one done cycle with wb_valid_o high and the assembled word on wb_data_o, so busy lasts 9 cycles.
- R3: Store (op 1) writes operand A to base = operand B in 8 write cycles, followed by the done cycle. It gives no writeback.
- R4: Copy (op 2) reads 8 bytes starting at operand B, then writes them in 8 cycles starting at operand A, then gives done. It gives no writeback, and busy lasts 17 cycles.
- R5: Immediate move (op 3) gives done with wb_valid_o in the cycle after acceptance. wb_data_o carries the 32-bit immediate zero-extended to 64 bits, and there is no memory access.
- R6: The address rises by exactly one between consecutive accesses of a phase and wraps modulo 2^64.
- R7: busy_o is high from the cycle after an accepted start through the one-cycle done pulse inclusive, and it is low in the cycle after done.
- R8: A start that arrives while busy_o is high is ignored. It changes neither the running transfer nor what follows.
- R9: After reset, and whenever the unit is idle, busy, done, valid, read and write are all low. Read and write are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request strobe, taken only when idle |
| op_i | input | 2 | 0 load, 1 store, 2 copy, 3 immediate move |
| opa_i | input | 64 | Operand A: store data or copy destination |
| opb_i | input | 64 | Operand B: source or target address |
| imm_i | input | 32 | Immediate for op 3 |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| wb_valid_o | output | 1 | Writeback valid, only with done |
| wb_data_o | output | 64 | Writeback value |
| mem_addr_o | output | 64 | Byte address |
| mem_re_o | output | 1 | Read strobe, data returned the same cycle |
| mem_we_o | output | 1 | Write strobe |
| mem_wdata_o | output | 8 | Write byte |
| mem_rdata_i | input | 8 | Read byte |

## Verification
A wrong byte counter or phase state shows up at the ports on the very next access. The result is then one of three things: a ninth or a missing strobe, a copy that starts writing early, or a done pulse that comes at the wrong cycle count. A broken address step or missing wrap appears as a repeated or skipped address in the captured address sequence. A swapped shift direction corrupts a word, and that corruption shows in the writeback of the next load from the same location. A start that leaks in while busy shows as a stray write or a busy period that runs long after done.

// File: rtl/lsu_pkg.sv
package lsu_pkg;
  typedef enum logic [1:0] {
    OP_LOAD  = 2'd0,
    OP_STORE = 2'd1,
    OP_COPY  = 2'd2,
    OP_IMM   = 2'd3
  } lsu_op_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_WRITE = 2'd2,
    ST_FIN   = 2'd3
  } lsu_state_e;
endpackage

// File: rtl/lsu_seq.sv
module lsu_seq
  import lsu_pkg::*;
#(
  parameter int NBYTES = 8
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  lsu_op_e    op_i,
  output logic       accept_o,
  output logic       to_write_o,
  output lsu_state_e state_o,
  output lsu_op_e    op_o
);
  localparam int CNT_W = (NBYTES > 1) ? $clog2(NBYTES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(NBYTES - 1);

  lsu_state_e state_q, state_d;
  lsu_op_e    op_q;
  logic [CNT_W-1:0] cnt_q;
  logic xfer, last;

  assign accept_o   = start_i && (state_q == ST_IDLE);
  assign xfer       = (state_q == ST_READ) || (state_q == ST_WRITE);
  assign last       = cnt_q == LAST;
  assign to_write_o = (state_q == ST_READ) && last && (op_q == OP_COPY);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (accept_o) begin
        unique case (op_i)
          OP_IMM:   state_d = ST_FIN;
          OP_STORE: state_d = ST_WRITE;
          default:  state_d = ST_READ;
        endcase
      end
      ST_READ:  if (last) state_d = (op_q == OP_COPY) ? ST_WRITE : ST_FIN;
      ST_WRITE: if (last) state_d = ST_FIN;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      op_q    <= OP_LOAD;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      if (accept_o) op_q <= op_i;
      if (xfer) cnt_q <= last ? '0 : cnt_q + 1'b1;
      else      cnt_q <= '0;
    end
  end

  assign state_o = state_q;
  assign op_o    = op_q;
endmodule

// File: rtl/lsu_addr_gen.sv
module lsu_addr_gen #(
  parameter int ADDR_W = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic              step_i,
  output logic [ADDR_W-1:0] addr_o
);
  logic [ADDR_W-1:0] addr_q;

  // load wins over step at the copy read->write turn
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     addr_q <= '0;
    else if (load_i) addr_q <= base_i;
    else if (step_i) addr_q <= addr_q + 1'b1;
  end

  assign addr_o = addr_q;
endmodule

// File: rtl/lsu_word_buf.sv
module lsu_word_buf #(
  parameter int DATA_W = 64,
  parameter int BYTE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DATA_W-1:0] load_val_i,
  input  logic              shift_i,
  input  logic [BYTE_W-1:0] byte_i,
  output logic [DATA_W-1:0] word_o,
  output logic [BYTE_W-1:0] byte_o
);
  logic [DATA_W-1:0] buf_q;

  // right shift: bytes read in enter at the top, so the first lands at the bottom
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      buf_q <= '0;
    else if (load_i)  buf_q <= load_val_i;
    else if (shift_i) buf_q <= {byte_i, buf_q[DATA_W-1:BYTE_W]};
  end

  assign word_o = buf_q;
  assign byte_o = buf_q[BYTE_W-1:0];
endmodule

// File: rtl/le_lsu.sv
module le_lsu
  import lsu_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int DATA_W = 64,
  parameter int BYTE_W = 8,
  parameter int IMM_W  = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [1:0]        op_i,
  input  logic [DATA_W-1:0] opa_i,
  input  logic [DATA_W-1:0] opb_i,
  input  logic [IMM_W-1:0]  imm_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              wb_valid_o,
  output logic [DATA_W-1:0] wb_data_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_re_o,
  output logic              mem_we_o,
  output logic [BYTE_W-1:0] mem_wdata_o,
  input  logic [BYTE_W-1:0] mem_rdata_i
);
  localparam int NBYTES = DATA_W / BYTE_W;

  lsu_state_e state;
  lsu_op_e    op_q, op_in;
  logic accept, to_write;
  logic [ADDR_W-1:0] dest_q;
  logic [DATA_W-1:0] init_val;

  assign op_in = lsu_op_e'(op_i);

  lsu_seq #(.NBYTES(NBYTES)) u_seq (
    .clk_i, .rst_ni, .start_i,
    .op_i      (op_in),
    .accept_o  (accept),
    .to_write_o(to_write),
    .state_o   (state),
    .op_o      (op_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      dest_q <= '0;
    else if (accept)  dest_q <= ADDR_W'(opa_i);
  end

  assign mem_re_o = state == ST_READ;
  assign mem_we_o = state == ST_WRITE;

  lsu_addr_gen #(.ADDR_W(ADDR_W)) u_addr (
    .clk_i, .rst_ni,
    .load_i(accept || to_write),
    .base_i(accept ? ADDR_W'(opb_i) : dest_q),
    .step_i(mem_re_o || mem_we_o),
    .addr_o(mem_addr_o)
  );

  always_comb begin
    unique case (op_in)
      OP_STORE: init_val = opa_i;
      OP_IMM:   init_val = DATA_W'(imm_i);
      default:  init_val = '0;
    endcase
  end

  lsu_word_buf #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_buf (
    .clk_i, .rst_ni,
    .load_i    (accept),
    .load_val_i(init_val),
    .shift_i   (mem_re_o || mem_we_o),
    .byte_i    (mem_re_o ? mem_rdata_i : '0),
    .word_o    (wb_data_o),
    .byte_o    (mem_wdata_o)
  );

  assign busy_o     = state != ST_IDLE;
  assign done_o     = state == ST_FIN;
  assign wb_valid_o = done_o && (op_q == OP_LOAD || op_q == OP_IMM);
endmodule

// File: rtl/le_lsu_checker.sv
module le_lsu_checker #(
  parameter int ADDR_W = 64
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              busy_o,
  input logic              done_o,
  input logic              wb_valid_o,
  input logic              mem_re_o,
  input logic              mem_we_o,
  input logic [ADDR_W-1:0] mem_addr_o
);
  p_rw_excl_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_re_o && mem_we_o));

  p_done_busy_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> busy_o);

  p_idle_after_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !busy_o);

  p_hold_busy_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !done_o) |=> busy_o);

  p_addr_step_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((mem_re_o && $past(mem_re_o)) || (mem_we_o && $past(mem_we_o)))
      |-> mem_addr_o == $past(mem_addr_o) + 1'b1);

  p_wb_done_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_valid_o |-> done_o);

  p_idle_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !(mem_re_o || mem_we_o || done_o));
endmodule

bind le_lsu le_lsu_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i, .rst_ni, .busy_o, .done_o, .wb_valid_o,
  .mem_re_o, .mem_we_o, .mem_addr_o
);

// File: tb/le_lsu_test.sv
module le_lsu_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [1:0] op = 2'd0;
  logic [63:0] opa = '0, opb = '0;
  logic [31:0] imm = '0;
  logic busy, done, wbv_o, re, we;
  logic [63:0] wbd, addr;
  logic [7:0] wdata, rdata;
  logic [7:0] mem [256];
  logic [63:0] alog [20];
  int acnt, rcnt, wcnt;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  le_lsu uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .op_i(op),
    .opa_i(opa), .opb_i(opb), .imm_i(imm),
    .busy_o(busy), .done_o(done), .wb_valid_o(wbv_o), .wb_data_o(wbd),
    .mem_addr_o(addr), .mem_re_o(re), .mem_we_o(we),
    .mem_wdata_o(wdata), .mem_rdata_i(rdata)
  );

  always @(posedge clk) if (we) mem[addr[7:0]] <= wdata;
  assign rdata = mem[addr[7:0]];

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // inj >= 0: pulse a store start at that busy cycle
  task automatic run_op(input logic [1:0] o, input logic [63:0] a, input logic [63:0] b,
                        input logic [31:0] im, input int inj,
                        output int cyc, output logic [63:0] wb, output logic wv);
    @(negedge clk);
    start = 1'b1; op = o; opa = a; opb = b; imm = im;
    @(negedge clk);
    start = 1'b0;
    cyc = 0; acnt = 0; rcnt = 0; wcnt = 0; wv = 1'b0; wb = '0;
    forever begin
      cyc++;
      if (re || we) begin
        if (acnt < 20) alog[acnt] = addr;
        acnt++;
      end
      if (re) rcnt++;
      if (we) wcnt++;
      if (done) begin
        wb = wbd; wv = wbv_o;
        break;
      end
      if (cyc > 40) begin
        chk(1'b0, "R7 timeout", 64'(cyc), 64'd17);
        break;
      end
      if (cyc == inj) begin
        start = 1'b1; op = 2'd1; opa = '0;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
    end
    start = 1'b0;
    @(negedge clk);
    chk(!busy && !done, "R7 busy after done", {62'd0, busy, done}, 64'd0);
  endtask

  localparam int NV = 7;
  // {op[2], a[64], b[64], imm[32], exp[64]}
  localparam logic [225:0] VEC [NV] = '{
    {2'd1, 64'h1122334455667788, 64'h20, 32'h0, 64'h0},
    {2'd0, 64'h0, 64'h20, 32'h0, 64'h1122334455667788},
    {2'd3, 64'h0, 64'h0, 32'h89ABCDEF, 64'h0000000089ABCDEF},
    {2'd2, 64'h40, 64'h20, 32'h0, 64'h0},
    {2'd0, 64'h0, 64'h40, 32'h0, 64'h1122334455667788},
    {2'd1, 64'hDEADBEEF00C0FFEE, 64'h23, 32'h0, 64'h0},
    {2'd0, 64'h0, 64'h20, 32'h0, 64'hEF00C0FFEE667788}
  };

  initial begin
    #800000;
    chk(1'b0, "R7 watchdog", 64'd0, 64'd1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int cyc;
    logic [63:0] wb;
    logic wv;
    repeat (3) @(negedge clk);
    chk({busy, done, wbv_o, re, we} == 5'b0, "R9 reset", {59'd0, busy, done, wbv_o, re, we}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      logic [1:0] vo;
      int ec, er, ew;
      vo = VEC[i][225:224];
      run_op(vo, VEC[i][223:160], VEC[i][159:96], VEC[i][95:64], -1, cyc, wb, wv);
      ec = (vo == 2'd2) ? 17 : (vo == 2'd3) ? 1 : 9;
      er = (vo == 2'd0 || vo == 2'd2) ? 8 : 0;
      ew = (vo == 2'd1 || vo == 2'd2) ? 8 : 0;
      chk(cyc == ec, "R7 busy length", 64'(cyc), 64'(ec));
      chk(rcnt == er && wcnt == ew, (vo == 2'd2) ? "R4 access counts" : "R3 access counts",
          {32'(rcnt), 32'(wcnt)}, {32'(er), 32'(ew)});
      if (vo == 2'd0 || vo == 2'd3) begin
        chk(wv, (vo == 2'd0) ? "R2 valid" : "R5 valid", {63'd0, wv}, 64'd1);
        chk(wb == VEC[i][63:0], (vo == 2'd0) ? "R2 data" : "R5 data", wb, VEC[i][63:0]);
      end else begin
        chk(!wv, "R3 no writeback", {63'd0, wv}, 64'd0);
      end
    end

    // R1 byte placement after the overlapping store
    chk(mem[8'h20] == 8'h88, "R1 byte0", {56'd0, mem[8'h20]}, 64'h88);
    chk(mem[8'h23] == 8'hEE, "R1 byte3", {56'd0, mem[8'h23]}, 64'hEE);
    chk(mem[8'h27] == 8'hEF, "R1 byte7", {56'd0, mem[8'h27]}, 64'hEF);

    // R4 copy address order
    run_op(2'd2, 64'h80, 64'h40, 32'h0, -1, cyc, wb, wv);
    chk(alog[0] == 64'h40 && alog[7] == 64'h47, "R4 read addrs", alog[7], 64'h47);
    chk(alog[8] == 64'h80 && alog[15] == 64'h87, "R4 write addrs", alog[15], 64'h87);
    run_op(2'd0, 64'h0, 64'h80, 32'h0, -1, cyc, wb, wv);
    chk(wb == 64'h1122334455667788, "R4 copied word", wb, 64'h1122334455667788);

    // R6 wrap across the top of the address space
    run_op(2'd1, 64'h0102030405060708, 64'hFFFF_FFFF_FFFF_FFFC, 32'h0, -1, cyc, wb, wv);
    chk(alog[3] == 64'hFFFF_FFFF_FFFF_FFFF, "R6 top addr", alog[3], 64'hFFFF_FFFF_FFFF_FFFF);
    chk(alog[4] == 64'h0 && alog[7] == 64'h3, "R6 wrapped addr", alog[4], 64'h0);
    chk(mem[8'hFC] == 8'h08 && mem[8'h03] == 8'h01, "R1 wrapped bytes", {48'd0, mem[8'hFC], mem[8'h03]}, 64'h0801);
    run_op(2'd0, 64'h0, 64'hFFFF_FFFF_FFFF_FFFC, 32'h0, -1, cyc, wb, wv);
    chk(wb == 64'h0102030405060708, "R6 wrapped load", wb, 64'h0102030405060708);

    // R8 start while busy is ignored
    run_op(2'd0, 64'h0, 64'h40, 32'h0, 3, cyc, wb, wv);
    chk(cyc == 9 && wcnt == 0, "R8 running load unchanged", {32'(cyc), 32'(wcnt)}, {32'd9, 32'd0});
    chk(wb == 64'h1122334455667788, "R8 load data", wb, 64'h1122334455667788);
    @(negedge clk);
    chk(!busy && !we, "R8 no late start", {62'd0, busy, we}, 64'd0);

    // R5 immediate with upper bits set stays zero-extended
    run_op(2'd3, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 32'hFFFF_FFFF, -1, cyc, wb, wv);
    chk(wb == 64'h0000_0000_FFFF_FFFF && acnt == 0, "R5 zero extend", wb, 64'h0000_0000_FFFF_FFFF);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule